// File: doc/BRIEF.md
# Dual-Modulus Pulse-Swallow Feedback Divider

This block divides a fast input clock by a programmable ratio N = B·P + A and hands one pulse per division cycle to a phase detector. A small prescaler divides the input clock by either P or P+1, depending on a modulus-control signal. Two down-counters sit behind it. The swallow counter (A) holds the prescaler at P+1 for its first A periods. The main counter (B) counts all B prescaler periods of the cycle. A division cycle is A periods of P+1 input clocks followed by B−A periods of P input clocks.

Software writes A (6 bits), B (13 bits) and a 2-bit prescaler pair select, then raises a load strobe. A legal request needs B of at least 3 and A no larger than B. The block holds a legal request in a pending register and copies it into the counters and the prescaler only when the running cycle ends, so no cycle is ever cut short or stretched. An illegal request is dropped and raises an error flag. The prescaler is modelled as synchronous logic clocked by the input clock.

Top module: `pulse_swallow_divider`

## Requirements
- R1: Successive rising edges of `div_out` are exactly B·P + A input clock cycles apart. P is chosen by `psel`: 2'b00 gives 8, 2'b01 gives 16, 2'b10 gives 32, 2'b11 gives 64.
- R2: `div_out` stays high for exactly one input clock cycle per division cycle.
- R3: `mod_ctl` goes high at the start of each division cycle when A is nonzero. It stays high for exactly A·(P+1) input clock cycles and is low for the rest of the cycle. With A = 0 it never goes high.
- R4: A legal load does not change the division cycle in progress, which completes with its old length. The cycle after it uses the new A, B and P.
- R5: A load with A > B or B < 3 is rejected. `cfg_err` is high in the cycle after the load, and the division ratio stays unchanged.
- R6: A legal load clears `cfg_err` in the cycle after the load.
- R7: After reset, `div_out`, `mod_ctl` and `cfg_err` are low. The divider runs at A = 0, B = 3, P = 8, and its first pulse rises 24 cycles after reset is released.
- R8: The edge settings still divide by B·P + A. These are A = B (every prescaler period is P+1), the minimum B of 3, and A = 63 with a large B.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock to be divided |
| rst_n | input | 1 | Synchronous reset, active low |
| a_val | input | 6 | Requested swallow count A |
| b_val | input | 13 | Requested main count B |
| psel | input | 2 | Requested prescaler pair select |
| load | input | 1 | Strobe that captures a_val, b_val and psel |
| div_out | output | 1 | One-cycle pulse per division cycle |
| mod_ctl | output | 1 | High while the prescaler divides by P+1 |
| cfg_err | output | 1 | Last load request was illegal |

## Verification
`cfg_err` is registered: it is due one cycle after the edge that captures `load`. The bench therefore reads it on the first falling edge after raising `load`. `div_out` rises at the edge that closes a division cycle. The bench drives each load while it sees a pulse, then counts falling edges to the next pulse and expects the old N there. It expects the new N only over the interval after that. The bench counts `mod_ctl` over the same falling-edge samples, from the pulse sample up to but not including the next one, and compares the total with A·(P+1). The sweep covers every prescaler pair against a small grid of A and B, plus random legal settings.

// File: rtl/psd_pkg.sv
// Shared widths and types for the pulse-swallow divider.
// Assumes the prescaler pair is a power of two selected by a small code.
package psd_pkg;
    localparam int A_W        = 6;   // swallow counter width
    localparam int B_W        = 13;  // main counter width
    localparam int SEL_W      = 2;   // prescaler select width
    localparam int P_LOG2_MIN = 3;   // smallest pair is 2**3 / 2**3+1
    localparam int MIN_B      = 3;   // smallest legal main count
    localparam int NSEL       = 1 << SEL_W;
    localparam int PC_W       = P_LOG2_MIN + NSEL; // holds the largest P

    typedef logic [A_W-1:0]   a_cnt_t;
    typedef logic [B_W-1:0]   b_cnt_t;
    typedef logic [SEL_W-1:0] sel_t;
    typedef logic [PC_W-1:0]  pc_t;

    typedef struct packed {
        a_cnt_t a;
        b_cnt_t b;
        sel_t   sel;
    } div_cfg_t;
endpackage

// File: rtl/psd_cfg_hold.sv
// Configuration holding stage.
// Checks each load request, keeps legal ones in a pending register and
// hands the prescaler select over only at a division-cycle boundary.
// Assumes boundary is a one-cycle strobe from the swallow counters.
module psd_cfg_hold
    import psd_pkg::*;
#(
    parameter int DEF_A   = 0,
    parameter int DEF_B   = 3,
    parameter int DEF_SEL = 0
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     load,
    input  a_cnt_t   a_in,
    input  b_cnt_t   b_in,
    input  sel_t     sel_in,
    input  logic     boundary,
    output div_cfg_t pend,
    output sel_t     act_sel,
    output logic     cfg_err
);
    logic bad_req;

    // Purpose: flag a request that would break the A <= B, B >= MIN_B rule.
    always_comb begin
        bad_req = (b_in < b_cnt_t'(MIN_B)) || (b_cnt_t'(a_in) > b_in);
    end

    // Purpose: capture legal requests and track the error flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend.a   <= a_cnt_t'(DEF_A);
            pend.b   <= b_cnt_t'(DEF_B);
            pend.sel <= sel_t'(DEF_SEL);
            cfg_err  <= 1'b0;
        end else if (load) begin
            if (bad_req) begin
                cfg_err <= 1'b1;
            end else begin
                pend.a   <= a_in;
                pend.b   <= b_in;
                pend.sel <= sel_in;
                cfg_err  <= 1'b0;
            end
        end
    end

    // Purpose: switch the prescaler pair only when a cycle ends.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_sel <= sel_t'(DEF_SEL);
        end else if (boundary) begin
            act_sel <= pend.sel;
        end
    end

    // R5: the pending setting is always a legal one
    p_pend_legal_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (pend.b >= b_cnt_t'(MIN_B)) && (b_cnt_t'(pend.a) <= pend.b));

    // R5: a rejected request raises the flag on the next cycle
    p_reject_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (load && bad_req) |=> cfg_err);

    // R6: a legal request clears the flag on the next cycle
    p_accept_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (load && !bad_req) |=> !cfg_err);

    // R4: the active pair never moves outside a boundary
    p_sel_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !boundary |=> $stable(act_sel));
endmodule

// File: rtl/psd_prescaler.sv
// Synchronous dual-modulus prescaler.
// Divides the input clock by P or P+1 and emits a one-cycle tick at the
// last input cycle of each period. Assumes mod and sel change only on the
// edge at which a tick is issued.
module psd_prescaler
    import psd_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  sel_t sel,
    input  logic mod,
    output logic tick
);
    pc_t mod_tab [NSEL];
    pc_t p_val;
    pc_t lim;
    pc_t pc;

    // One modulus per select code: P = 2**(P_LOG2_MIN + code).
    for (genvar g = 0; g < NSEL; g++) begin : g_modulus
        assign mod_tab[g] = pc_t'(1) << (P_LOG2_MIN + g);
    end

    // Purpose: pick the terminal count for the current period.
    always_comb begin
        p_val = mod_tab[sel];
        lim   = mod ? p_val : (p_val - pc_t'(1));
        tick  = (pc == lim);
    end

    // Purpose: count input cycles within one prescaler period.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc <= '0;
        end else if (tick) begin
            pc <= '0;
        end else begin
            pc <= pc + pc_t'(1);
        end
    end

    // R1: the period counter never runs past P+1 states
    p_pc_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
        pc <= p_val);
endmodule

// File: rtl/psd_swallow.sv
// Swallow (A) and main (B) counters.
// Both count prescaler periods. A holds the prescaler at P+1 while
// nonzero; the period in which B is at one closes the division cycle,
// and both counters then reload from the pending setting.
// Assumes the reload values already satisfy A <= B and B >= 3.
module psd_swallow
    import psd_pkg::*;
#(
    parameter int DEF_A = 0,
    parameter int DEF_B = 3
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   tick,
    input  a_cnt_t rl_a,
    input  b_cnt_t rl_b,
    output logic   mod_ctl,
    output logic   boundary
);
    a_cnt_t a_rem;
    b_cnt_t b_rem;
    logic   last_period;

    // Purpose: decode modulus and cycle end from the remaining counts.
    always_comb begin
        last_period = (b_rem == b_cnt_t'(1));
        boundary    = tick && last_period;
        mod_ctl     = (a_rem != '0);
    end

    // Purpose: step both counters once per prescaler period.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_rem <= a_cnt_t'(DEF_A);
            b_rem <= b_cnt_t'(DEF_B);
        end else if (tick) begin
            if (last_period) begin
                a_rem <= rl_a;
                b_rem <= rl_b;
            end else begin
                b_rem <= b_rem - b_cnt_t'(1);
                if (a_rem != '0) begin
                    a_rem <= a_rem - a_cnt_t'(1);
                end
            end
        end
    end

    // R3: the swallow count never exceeds the periods left
    p_a_le_b_r3: assert property (@(posedge clk) disable iff (!rst_n)
        b_cnt_t'(a_rem) <= b_rem);

    // R1: the main counter never sits at zero
    p_b_nonzero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        b_rem != '0);

    // R3: after the last period the modulus matches the reloaded A
    p_mod_reload_r3: assert property (@(posedge clk) disable iff (!rst_n)
        boundary |=> (mod_ctl == ($past(rl_a) != '0)));
endmodule

// File: rtl/pulse_swallow_divider.sv
// Top of the pulse-swallow feedback divider: N = B*P + A.
// Ties the configuration stage, prescaler and swallow counters together
// and registers the output pulse. Assumes clk is the clock to be divided.
module pulse_swallow_divider #(
    parameter int DEF_A   = 0,
    parameter int DEF_B   = 3,
    parameter int DEF_SEL = 0
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [psd_pkg::A_W-1:0]     a_val,
    input  logic [psd_pkg::B_W-1:0]     b_val,
    input  logic [psd_pkg::SEL_W-1:0]   psel,
    input  logic                        load,
    output logic                        div_out,
    output logic                        mod_ctl,
    output logic                        cfg_err
);
    import psd_pkg::*;

    div_cfg_t pend;
    sel_t     act_sel;
    logic     tick;
    logic     boundary;

    psd_cfg_hold #(
        .DEF_A   (DEF_A),
        .DEF_B   (DEF_B),
        .DEF_SEL (DEF_SEL)
    ) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .a_in     (a_val),
        .b_in     (b_val),
        .sel_in   (psel),
        .boundary (boundary),
        .pend     (pend),
        .act_sel  (act_sel),
        .cfg_err  (cfg_err)
    );

    psd_prescaler u_presc (
        .clk   (clk),
        .rst_n (rst_n),
        .sel   (act_sel),
        .mod   (mod_ctl),
        .tick  (tick)
    );

    psd_swallow #(
        .DEF_A (DEF_A),
        .DEF_B (DEF_B)
    ) u_swallow (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .rl_a     (pend.a),
        .rl_b     (pend.b),
        .mod_ctl  (mod_ctl),
        .boundary (boundary)
    );

    // Purpose: register the cycle-end strobe as a clean output pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_out <= 1'b0;
        end else begin
            div_out <= boundary;
        end
    end

    // R2: the output pulse lasts a single input cycle
    p_pulse_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        div_out |=> !div_out);

    // R3: a new cycle never opens with a period still pending from the last
    p_pulse_from_tick_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(div_out) |-> $past(tick));
endmodule

// File: tb/pulse_swallow_divider_bench.sv
`timescale 1ns/1ps
module pulse_swallow_divider_bench;
    logic        clk    = 1'b0;
    logic        rst_n  = 1'b0;
    logic        load   = 1'b0;
    logic [5:0]  a_val  = '0;
    logic [12:0] b_val  = 13'd3;
    logic [1:0]  psel   = '0;
    logic        div_out;
    logic        mod_ctl;
    logic        cfg_err;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    int cur_a  = 0;
    int cur_b  = 3;
    int cur_p  = 8;

    localparam int WATCHDOG = 190000;

    pulse_swallow_divider u_pulse_swallow_divider (
        .clk     (clk),
        .rst_n   (rst_n),
        .a_val   (a_val),
        .b_val   (b_val),
        .psel    (psel),
        .load    (load),
        .div_out (div_out),
        .mod_ctl (mod_ctl),
        .cfg_err (cfg_err)
    );

    always #2 clk = ~clk;   // 250 MHz

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > WATCHDOG) begin
            checks++;
            fails++;
            $display("FAIL R1 watchdog: actual %0d cycles expected below %0d", cyc, WATCHDOG);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    // Starts on a falling edge where div_out is high; ends on the next such edge.
    task automatic measure(output int len, output int mhi, output bit s1_div, output bit s1_err);
        len    = 0;
        mhi    = mod_ctl ? 1 : 0;
        s1_div = 1'b0;
        s1_err = 1'b0;
        while (1) begin
            @(negedge clk);
            len++;
            if (len == 1) begin
                load   = 1'b0;
                s1_div = div_out;
                s1_err = cfg_err;
            end
            if (div_out) break;
            if (mod_ctl) mhi++;
        end
    endtask

    task automatic run_cfg(input int a, input int b, input int ps);
        bit    ok;
        int    old_n, old_m, new_n, new_m, len, mhi;
        bit    d1, e1;
        string tag;
        ok    = (b >= 3) && (a <= b);
        old_n = cur_b * cur_p + cur_a;
        old_m = cur_a * (cur_p + 1);
        a_val = 6'(a);
        b_val = 13'(b);
        psel  = 2'(ps);
        load  = 1'b1;
        measure(len, mhi, d1, e1);
        check(len == old_n, "R4 cycle in progress keeps old length", len, old_n);
        check(mhi == old_m, "R3 modulus-high cycles", mhi, old_m);
        check(d1 == 1'b0, "R2 pulse width", int'(d1), 0);
        if (ok) check(e1 == 1'b0, "R6 error flag cleared", int'(e1), 0);
        else    check(e1 == 1'b1, "R5 error flag raised", int'(e1), 1);
        if (ok) begin
            cur_a = a;
            cur_b = b;
            cur_p = 8 << ps;
        end
        new_n = cur_b * cur_p + cur_a;
        new_m = cur_a * (cur_p + 1);
        if (!ok) tag = "R5 ratio unchanged after rejected load";
        else if (cur_a == cur_b || cur_b == 3 || cur_a == 63) tag = "R8 edge setting ratio";
        else tag = "R1 division ratio";
        measure(len, mhi, d1, e1);
        check(len == new_n, tag, len, new_n);
        check(mhi == new_m, "R3 modulus-high cycles", mhi, new_m);
    endtask

    initial begin
        int len;
        repeat (4) @(negedge clk);
        check(div_out == 1'b0, "R7 div_out in reset", int'(div_out), 0);
        check(mod_ctl == 1'b0, "R7 mod_ctl in reset", int'(mod_ctl), 0);
        check(cfg_err == 1'b0, "R7 cfg_err in reset", int'(cfg_err), 0);
        rst_n = 1'b1;
        len = 0;
        do begin
            @(negedge clk);
            len++;
        end while (!div_out);
        check(len == 24, "R7 first pulse after reset", len, 24);

        // Near-exhaustive grid: every pair, several B, A at 0, 1 and B.
        for (int ps = 0; ps < 4; ps++) begin
            for (int bi = 0; bi < 3; bi++) begin
                int b;
                b = (bi == 0) ? 3 : ((bi == 1) ? 5 : 9);
                run_cfg(0, b, ps);
                run_cfg(1, b, ps);
                run_cfg(b, b, ps);
            end
        end

        // Rejected requests: A above B, B below 3, B zero.
        run_cfg(10, 5, 1);
        run_cfg(0, 2, 2);
        run_cfg(0, 0, 3);
        run_cfg(2, 4, 0);   // legal load clears the flag

        // Randomised legal settings.
        for (int k = 0; k < 12; k++) begin
            int b, a, ps;
            b  = int'($urandom_range(24, 3));
            a  = int'($urandom_range(b, 0));
            ps = int'($urandom_range(3, 0));
            run_cfg(a, b, ps);
        end

        // Largest swallow count with a long main count.
        run_cfg(63, 2000, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule